// File: doc/BRIEF.md
# Hashed Two-Way Page Translation Cache

This block keeps recently used virtual-to-physical page translations for a 32-bit address space with 4 KiB pages. It has eight sets of two ways. A 3-bit set index is formed by XOR-folding masked groups of page-number bits, so neighbouring pages spread across the sets instead of piling into one. A lookup answers in the same cycle from registered state. A miss names a victim way and parks the request until an external page-table walker returns the physical page number on the fill port.

Each set has one replacement bit that points at the way to evict next. A flush input invalidates everything by writing a tag value that no real page number can produce. Per-set, per-way hit and miss counters are kept. Load and store traffic are each expected to use their own instance.

Top module: `xlat_cache`

## Requirements
- R1: After reset, `lk_ready` is 1, `lk_hit` and `lk_miss` are 0 while no lookup is presented, every counter reads 0, and every lookup misses.
- R2: With the page number P = vaddr[31:12] zero-extended to 32 bits, the set index is {^(P & 32'hAAAAAAAA), ^(P & 32'h55555555), ^(P & 32'hCCCCCCCC)} (bit 2 down to bit 0). Counter slot k = set*2 + way holds bits [k*CNT_W +: CNT_W] of `hit_cnt` and `miss_cnt`.
- R3: A lookup hit (`lk_valid` with `lk_ready` high and a matching way) raises `lk_hit` in the same cycle, and `lk_paddr` = {cached PPN, vaddr[11:0]}. `lk_paddr` is 0 whenever `lk_hit` is low, and `lk_hit` and `lk_miss` are never high together.
- R4: A lookup miss raises `lk_miss` in the same cycle. From the next cycle `lk_ready` stays low until a fill is taken. While it is low, lookups produce neither `lk_hit` nor `lk_miss` and change no counter.
- R5: `fill_valid` while a miss is outstanding writes the missed page number and `fill_ppn` into the victim way and raises `lk_ready` on the next cycle. A later lookup of that page hits.
- R6: Each set has a replacement bit. A hit on way w sets it to 1-w. A miss evicts the way it names, and the fill then sets it to the other way.
- R7: `flush` invalidates every way, points every set's replacement bit at way 0, drops any outstanding miss, and keeps `lk_ready` low in its own cycle. Counters are not cleared.
- R8: A hit adds 1 to the hit counter of the hitting way. A miss adds 1 to the miss counter of the victim way.
- R9: Page number 20'hFFFFF never matches an invalid way, and it can be cached and hit like any other page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all translations |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_ready | output | 1 | Lookup accepted this cycle |
| lk_hit | output | 1 | Accepted lookup hit |
| lk_miss | output | 1 | Accepted lookup missed; fill expected |
| lk_paddr | output | VA_W | Translated address on a hit, else 0 |
| fill_valid | input | 1 | Walker result strobe |
| fill_ppn | input | VA_W-PAGE_SHIFT | Physical page number from the walker |
| hit_cnt | output | 16*CNT_W | Hit counters, slot set*2+way |
| miss_cnt | output | 16*CNT_W | Miss counters, slot set*2+way |

## Verification
The properties assume that `fill_valid` is raised only while a miss is outstanding and that a lookup can be held across stalled cycles without harm. They also assume that `flush` may arrive in any cycle, including one with a pending miss. The stimulus raises the fill strobe only in the cycle after an observed miss, except for one deliberate flush that abandons a pending miss. It also holds a lookup over a stalled cycle on purpose, so the stall behaviour is exercised and not just asserted.

// File: rtl/xlc_pkg.sv
package xlc_pkg;

    localparam int XLC_SET_W = 3;
    localparam int XLC_SETS  = 1 << XLC_SET_W;
    localparam int XLC_WAYS  = 2;
    localparam int XLC_NCNT  = XLC_SETS * XLC_WAYS;

    // Fold masks, index = set-index bit they produce
    localparam logic [XLC_SET_W-1:0][31:0] XLC_FOLD_MASK = {
        32'hAAAAAAAA,   // bit 2: odd page-number bits
        32'h55555555,   // bit 1: even page-number bits
        32'hCCCCCCCC    // bit 0: upper half of every nibble
    };

    function automatic logic xlc_fold(input logic [31:0] v, input logic [31:0] m);
        return ^(v & m);
    endfunction

endpackage

// File: rtl/xlc_set_hash.sv
module xlc_set_hash
    import xlc_pkg::*;
#(
    parameter int VPN_W = 20
) (
    input  logic [VPN_W-1:0]     vpn,
    output logic [XLC_SET_W-1:0] set_idx
);

    logic [31:0] vpn_ext;
    assign vpn_ext = 32'(vpn);

    for (genvar b = 0; b < XLC_SET_W; b++) begin : g_fold
        assign set_idx[b] = xlc_fold(vpn_ext, XLC_FOLD_MASK[b]);
    end

endmodule

// File: rtl/xlc_way_cmp.sv
module xlc_way_cmp #(
    parameter int TAG_W = 21,
    parameter int PPN_W = 20,
    parameter int WAYS  = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0][PPN_W-1:0] ppns,
    input  logic [TAG_W-1:0]           key,
    output logic                       hit,
    output logic [WAY_W-1:0]           way,
    output logic [PPN_W-1:0]           ppn
);

    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_eq
        assign eq[w] = (tags[w] == key);
    end

    // Lowest-numbered matching way wins
    always_comb begin
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) way = WAY_W'(w);
        end
    end

    assign hit = |eq;
    assign ppn = ppns[way];

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlc_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int CNT_W      = 16,
    localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      lk_valid,
    input  logic [VA_W-1:0]           lk_vaddr,
    output logic                      lk_ready,
    output logic                      lk_hit,
    output logic                      lk_miss,
    output logic [VA_W-1:0]           lk_paddr,
    input  logic                      fill_valid,
    input  logic [VPN_W-1:0]          fill_ppn,
    output logic [XLC_NCNT*CNT_W-1:0] hit_cnt,
    output logic [XLC_NCNT*CNT_W-1:0] miss_cnt
);

    // One spare tag bit: real tags carry a 0 there, invalid is all ones
    localparam int TAG_W = VPN_W + 1;
    localparam int IDX_W = $clog2(XLC_NCNT);

    typedef struct packed {
        logic [XLC_SETS-1:0][XLC_WAYS-1:0][TAG_W-1:0] tag;
        logic [XLC_SETS-1:0][XLC_WAYS-1:0][VPN_W-1:0] ppn;
        logic [XLC_SETS-1:0]                          ptr;
        logic                                         pend;
        logic [XLC_SET_W-1:0]                         pset;
        logic                                         pway;
        logic [VPN_W-1:0]                             pvpn;
        logic [XLC_NCNT-1:0][CNT_W-1:0]               hits;
        logic [XLC_NCNT-1:0][CNT_W-1:0]               misses;
    } state_t;

    state_t s_d, s_q;

    logic [VPN_W-1:0]     vpn;
    logic [XLC_SET_W-1:0] set_idx;
    logic                 match;
    logic                 mway;
    logic [VPN_W-1:0]     mppn;
    logic                 accept;
    logic                 victim;
    logic [IDX_W-1:0]     hit_slot;
    logic [IDX_W-1:0]     miss_slot;

    assign vpn = lk_vaddr[VA_W-1:PAGE_SHIFT];

    xlc_set_hash #(
        .VPN_W (VPN_W)
    ) u_hash (
        .vpn     (vpn),
        .set_idx (set_idx)
    );

    xlc_way_cmp #(
        .TAG_W (TAG_W),
        .PPN_W (VPN_W),
        .WAYS  (XLC_WAYS)
    ) u_cmp (
        .tags (s_q.tag[set_idx]),
        .ppns (s_q.ppn[set_idx]),
        .key  ({1'b0, vpn}),
        .hit  (match),
        .way  (mway),
        .ppn  (mppn)
    );

    assign lk_ready  = ~s_q.pend & ~flush;
    assign accept    = lk_valid & lk_ready;
    assign lk_hit    = accept & match;
    assign lk_miss   = accept & ~match;
    assign lk_paddr  = lk_hit ? {mppn, lk_vaddr[PAGE_SHIFT-1:0]} : '0;
    assign victim    = s_q.ptr[set_idx];
    assign hit_slot  = {set_idx, mway};
    assign miss_slot = {set_idx, victim};

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.tag  = '1;
            s_d.ptr  = '0;
            s_d.pend = 1'b0;
        end else begin
            if (s_q.pend && fill_valid) begin
                s_d.tag[s_q.pset][s_q.pway] = {1'b0, s_q.pvpn};
                s_d.ppn[s_q.pset][s_q.pway] = fill_ppn;
                s_d.ptr[s_q.pset]           = ~s_q.pway;
                s_d.pend                    = 1'b0;
            end
            if (lk_hit) begin
                s_d.ptr[set_idx]  = ~mway;
                s_d.hits[hit_slot] = s_q.hits[hit_slot] + CNT_W'(1);
            end
            if (lk_miss) begin
                s_d.pend             = 1'b1;
                s_d.pset             = set_idx;
                s_d.pway             = victim;
                s_d.pvpn             = vpn;
                s_d.misses[miss_slot] = s_q.misses[miss_slot] + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.tag <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign hit_cnt  = s_q.hits;
    assign miss_cnt = s_q.misses;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int VA_W       = 32,
    parameter int PAGE_SHIFT = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            lk_ready,
    input logic            lk_hit,
    input logic            lk_miss,
    input logic [VA_W-1:0] lk_paddr,
    input logic            fill_valid
);

    // R3: hit and miss are exclusive
    p_hit_miss_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    // R3: page offset passes through on a hit
    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[PAGE_SHIFT-1:0] == lk_vaddr[PAGE_SHIFT-1:0]));

    // R3: address output quiet without a hit
    p_paddr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0));

    // R4: no result without a request or while stalled
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_valid || !lk_ready) |-> (!lk_hit && !lk_miss));

    // R4: a miss stalls the next cycle
    p_miss_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |=> !lk_ready);

    // R5: a fill during a stall releases it
    p_fill_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_ready && !flush && fill_valid) |=> (lk_ready || flush));

    // R7: flush drops an outstanding miss
    p_flush_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (lk_ready || flush));

endmodule

bind xlat_cache xlat_cache_chk #(
    .VA_W       (VA_W),
    .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lk_valid   (lk_valid),
    .lk_vaddr   (lk_vaddr),
    .lk_ready   (lk_ready),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .lk_paddr   (lk_paddr),
    .fill_valid (fill_valid)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;

    localparam int CLK_PERIOD = 10;
    localparam int VA_W  = 32;
    localparam int PS    = 12;
    localparam int VPN_W = VA_W - PS;
    localparam int CNT_W = 16;
    localparam int NCNT  = 16;
    localparam int NVEC  = 18;

    // {vaddr, fill ppn on miss, expect hit, expect paddr}
    localparam logic [84:0] VEC [NVEC] = '{
        {32'h00001123, 20'hAAAA1, 1'b0, 32'h00000000},
        {32'h00010456, 20'hAAAA2, 1'b0, 32'h00000000},
        {32'h00001FFF, 20'h00000, 1'b1, 32'hAAAA1FFF},
        {32'h00100000, 20'hAAAA3, 1'b0, 32'h00000000},
        {32'h00010004, 20'hBBBB2, 1'b0, 32'h00000000},
        {32'h00100ABC, 20'h00000, 1'b1, 32'hAAAA3ABC},
        {32'h00002010, 20'h12345, 1'b0, 32'h00000000},
        {32'h00004020, 20'h54321, 1'b0, 32'h00000000},
        {32'h00010777, 20'h00000, 1'b1, 32'hBBBB2777},
        {32'h00002EEE, 20'h00000, 1'b1, 32'h12345EEE},
        {32'h00004001, 20'h00000, 1'b1, 32'h54321001},
        {32'hFFFFFFFF, 20'h0F0F0, 1'b0, 32'h00000000},
        {32'hFFFFF800, 20'h00000, 1'b1, 32'h0F0F0800},
        {32'h00000000, 20'h11111, 1'b0, 32'h00000000},
        {32'h00000005, 20'h00000, 1'b1, 32'h11111005},
        {32'h00001000, 20'h22222, 1'b0, 32'h00000000},
        {32'h00100000, 20'h33333, 1'b0, 32'h00000000},
        {32'h00001234, 20'h00000, 1'b1, 32'h22222234}
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  flush = 1'b0;
    logic                  lk_valid = 1'b0;
    logic [VA_W-1:0]       lk_vaddr = '0;
    logic                  lk_ready;
    logic                  lk_hit;
    logic                  lk_miss;
    logic [VA_W-1:0]       lk_paddr;
    logic                  fill_valid = 1'b0;
    logic [VPN_W-1:0]      fill_ppn = '0;
    logic [NCNT*CNT_W-1:0] hit_cnt;
    logic [NCNT*CNT_W-1:0] miss_cnt;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_cache #(.VA_W(VA_W), .PAGE_SHIFT(PS), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
        .lk_vaddr(lk_vaddr), .lk_ready(lk_ready), .lk_hit(lk_hit),
        .lk_miss(lk_miss), .lk_paddr(lk_paddr), .fill_valid(fill_valid),
        .fill_ppn(fill_ppn), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
    );

    // Set index computed bit by bit from the fold rule
    function automatic int bench_set(input logic [31:0] va);
        logic [31:0] p = 32'(va[31:12]);
        logic b2 = 1'b0, b1 = 1'b0, b0 = 1'b0;
        for (int i = 0; i < 32; i++) begin
            if (i % 2 == 1) b2 ^= p[i];
            if (i % 2 == 0) b1 ^= p[i];
            if (i % 4 >= 2) b0 ^= p[i];
        end
        return int'({b2, b1, b0});
    endfunction

    function automatic logic [CNT_W-1:0] cget(input logic [NCNT*CNT_W-1:0] bus, input int slot);
        return bus[slot*CNT_W +: CNT_W];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Lookup; on a miss supply the fill the cycle after
    task automatic look(input logic [31:0] va, input logic exp_hit,
                        input logic [31:0] exp_pa, input logic [19:0] ppn, input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = va;
        #1;
        check({req, " hit"},  64'(lk_hit),  64'(exp_hit));
        check({req, " miss"}, 64'(lk_miss), 64'(!exp_hit));
        check({req, " paddr"}, 64'(lk_paddr), 64'(exp_hit ? exp_pa : 32'h0));
        @(negedge clk);
        lk_valid = 1'b0;
        if (!exp_hit) begin
            fill_valid = 1'b1;
            fill_ppn   = ppn;
            @(negedge clk);
            fill_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 ready", 64'(lk_ready), 64'd1);
        check("R1 hit idle", 64'(lk_hit), 64'd0);
        check("R1 hit counters", 64'(|hit_cnt), 64'd0);
        check("R1 miss counters", 64'(|miss_cnt), 64'd0);

        // Table walk: R2 R3 R5 R6 R9 (row 11 is page FFFFF, rows 3-4 and 15-17 evictions)
        for (int i = 0; i < NVEC; i++) begin
            look(VEC[i][84:53], VEC[i][32], VEC[i][31:0], VEC[i][52:33],
                 $sformatf("R3/R5/R6 row %0d", i));
        end

        // R8 and R2: counter slots follow the fold-hash set index
        check("R2 set of page 1",     64'(bench_set(32'h00001000)), 64'd2);
        check("R8 set2 way0 hits",    64'(cget(hit_cnt,  bench_set(32'h00001000)*2)),     64'd2);
        check("R8 set2 way1 hits",    64'(cget(hit_cnt,  bench_set(32'h00001000)*2 + 1)), 64'd2);
        check("R8 set2 way0 misses",  64'(cget(miss_cnt, bench_set(32'h00001000)*2)),     64'd3);
        check("R8 set2 way1 misses",  64'(cget(miss_cnt, bench_set(32'h00001000)*2 + 1)), 64'd3);
        check("R9 set0 way0 hits",    64'(cget(hit_cnt,  0)), 64'd1);
        check("R8 set0 way1 misses",  64'(cget(miss_cnt, 1)), 64'd1);
        check("R2 set4 way0 hits",    64'(cget(hit_cnt,  bench_set(32'h00002000)*2)), 64'd1);
        check("R2 set3 way0 misses",  64'(cget(miss_cnt, bench_set(32'h00004000)*2)), 64'd1);

        // R4: lookup while a miss is outstanding is ignored
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = 32'h00007000;
        #1;
        check("R4 miss raised", 64'(lk_miss), 64'd1);
        @(negedge clk);
        lk_vaddr = 32'h00002000;
        #1;
        check("R4 stalled ready", 64'(lk_ready), 64'd0);
        check("R4 stalled hit",   64'(lk_hit),   64'd0);
        check("R4 stalled miss",  64'(lk_miss),  64'd0);
        @(negedge clk);
        lk_valid   = 1'b0;
        fill_valid = 1'b1;
        fill_ppn   = 20'h77777;
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        check("R4 counter untouched", 64'(cget(hit_cnt, 8)), 64'd1);
        check("R5 ready after fill", 64'(lk_ready), 64'd1);
        look(32'h00007ABC, 1'b1, 32'h77777ABC, 20'h0, "R5 filled page");

        // R7: flush abandons a pending miss and invalidates
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = 32'h00008000;
        #1;
        check("R7 pre-flush miss", 64'(lk_miss), 64'd1);
        @(negedge clk);
        lk_valid = 1'b0;
        flush    = 1'b1;
        #1;
        check("R7 ready during flush", 64'(lk_ready), 64'd0);
        @(negedge clk);
        flush = 1'b0;
        #1;
        check("R7 ready after flush", 64'(lk_ready), 64'd1);
        check("R7 counters kept", 64'(cget(hit_cnt, 4)), 64'd2);
        look(32'h00002EEE, 1'b0, 32'h0, 20'h13579, "R7 flushed page");
        check("R7 victim way0 after flush", 64'(cget(miss_cnt, 8)), 64'd2);
        check("R7 way1 untouched", 64'(cget(miss_cnt, 9)), 64'd0);
        look(32'h00002001, 1'b1, 32'h13579001, 20'h0, "R7 refill hit");
        check("R8 hit after refill", 64'(cget(hit_cnt, 8)), 64'd2);
        look(32'h00001000, 1'b0, 32'h0, 20'h24680, "R7 set2 flushed");
        check("R6 pointer reset to way0", 64'(cget(miss_cnt, 4)), 64'd4);
        look(32'h00001FFC, 1'b1, 32'h24680FFC, 20'h0, "R3 final hit");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule